// File: doc/BRIEF.md
# Current Magnitude Trip Detector

The detector watches a stream of signed conversion results from a current-sensing channel. On each strobed sample it takes the magnitude of the two's-complement value and compares it with an unsigned trip level. Depending on a 2-bit mode it either stays quiet, raises its interrupt on the first sample at or above the level, or raises it only after enough qualifying samples have built up in a persistence counter.

The two persistence modes differ only in how a sample below the level is treated. One mode clears the counter outright, so only an unbroken run can trip. The other steps the counter down by one and stops at zero. This gives a leaky glitch filter that still trips on a mostly-high signal with short dips.

The interrupt is a sticky flag that holds until it is acknowledged. The counter value is presented on an output at all times so that it can be monitored.

Top module: `mag_trip_detector`

## Requirements
- R1: The comparison uses the magnitude of `smp_data`, read as two's complement, against the unsigned `trip_level`. A sample qualifies when its magnitude is greater than or equal to the level.
- R2: With `mode` = 2'b00 (off), `count` reads 0 and no interrupt is set.
- R3: With `mode` = 2'b01 (immediate), a qualifying strobed sample sets `irq` at the next clock edge, and `count` stays 0.
- R4: With `mode` = 2'b10 or 2'b11 (counting), a qualifying strobed sample raises `count` by one, saturating at `hold_limit`. `irq` is set at that same edge when the updated count equals `hold_limit`.
- R5: With `mode` = 2'b10, a strobed sample below the level clears `count` to 0.
- R6: With `mode` = 2'b11, a strobed sample below the level lowers `count` by one, stopping at 0.
- R7: `irq` stays set until `irq_ack` is sampled high. If a new trip happens in the same cycle as the acknowledge, the flag stays set. A cycle without `smp_valid` leaves `count` unchanged.
- R8: A cycle in which `mode` differs from its value in the previous cycle clears `count` to 0. The sample strobed in that cycle is discarded and cannot set `irq`.
- R9: The most negative sample value (0x8000 at 16 bits) takes the magnitude 0x7FFF.
- R10: With `hold_limit` = 0 in a counting mode, every qualifying sample sets `irq` and `count` stays 0.
- R11: While `rst_n` is low, `count` and `irq` are 0 and the remembered mode is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Strobe: `smp_data` holds a new result |
| smp_data | input | SAMPLE_W | Signed conversion result |
| trip_level | input | SAMPLE_W | Unsigned magnitude threshold |
| hold_limit | input | CNT_W | Number of qualifying samples needed to trip |
| mode | input | 2 | 00 off, 01 immediate, 10 count/clear, 11 count/leak |
| irq_ack | input | 1 | Clears the sticky interrupt |
| irq | output | 1 | Sticky trip interrupt |
| count | output | CNT_W | Persistence counter value |

## Verification
The bench builds the detector with a 16-bit sample and a 4-bit counter. With the narrow counter, saturation at the largest possible limit of 15 is reached in a few cycles, together with the limit-zero case. The 16-bit sample width puts the edge values ±100 around the level and the single most negative code within direct reach. Each persistence policy is walked through climbs, misses, leaks to zero and mode switches with a non-zero count.

// File: rtl/mtd_pkg.sv
package mtd_pkg;

    typedef enum logic [1:0] {
        MODE_OFF      = 2'b00,
        MODE_IMMED    = 2'b01,
        MODE_CNT_CLR  = 2'b10,
        MODE_CNT_LEAK = 2'b11
    } trip_mode_e;

    function automatic logic is_counting(input trip_mode_e m);
        return (m == MODE_CNT_CLR) || (m == MODE_CNT_LEAK);
    endfunction

endpackage

// File: rtl/mtd_magnitude.sv
module mtd_magnitude #(
    parameter int SAMPLE_W = 16
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] level,
    output logic                hit
);
    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
    localparam logic [SAMPLE_W-1:0] MAX_POS  = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic [SAMPLE_W-1:0] ONE      = {{(SAMPLE_W-1){1'b0}}, 1'b1};

    logic [SAMPLE_W-1:0] mag;

    always_comb begin
        if (sample == MOST_NEG) begin
            mag = MAX_POS;                 // no positive twin: saturate
        end else if (sample[SAMPLE_W-1]) begin
            mag = ~sample + ONE;
        end else begin
            mag = sample;
        end
        hit = (mag >= level);
    end
endmodule

// File: rtl/mtd_persist.sv
module mtd_persist #(
    parameter int CNT_W = 8
) (
    input  mtd_pkg::trip_mode_e mode,
    input  logic                clear,
    input  logic                step,
    input  logic                hit,
    input  logic [CNT_W-1:0]    limit,
    input  logic [CNT_W-1:0]    cnt_q,
    output logic [CNT_W-1:0]    cnt_d,
    output logic                reached
);
    import mtd_pkg::*;

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    always_comb begin
        cnt_d   = cnt_q;
        reached = 1'b0;
        if (clear || !is_counting(mode)) begin
            cnt_d = ZERO;
        end else if (step) begin
            if (hit) begin
                cnt_d   = (cnt_q >= limit) ? limit : cnt_q + ONE;
                reached = (cnt_d == limit);
            end else if (mode == MODE_CNT_CLR) begin
                cnt_d = ZERO;
            end else begin
                cnt_d = (cnt_q == ZERO) ? ZERO : cnt_q - ONE;
            end
        end
    end
endmodule

// File: rtl/mtd_flag.sv
module mtd_flag (
    input  logic set,
    input  logic ack,
    input  logic flag_q,
    output logic flag_d
);
    always_comb begin
        flag_d = set | (flag_q & ~ack);
    end
endmodule

// File: rtl/mag_trip_detector.sv
module mag_trip_detector #(
    parameter int SAMPLE_W = 16,
    parameter int CNT_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [SAMPLE_W-1:0] trip_level,
    input  logic [CNT_W-1:0]    hold_limit,
    input  logic [1:0]          mode,
    input  logic                irq_ack,
    output logic                irq,
    output logic [CNT_W-1:0]    count
);
    import mtd_pkg::*;

    typedef struct packed {
        trip_mode_e       mode;
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } state_t;

    localparam state_t RESET_STATE = '{mode: MODE_OFF, cnt: '0, irq: 1'b0};

    state_t           st_d, st_q;
    trip_mode_e       mode_in;
    logic             mode_chg;
    logic             step;
    logic             hit;
    logic             reached;
    logic             trip_set;
    logic [CNT_W-1:0] cnt_nxt;
    logic             irq_nxt;

    assign mode_in  = trip_mode_e'(mode);
    assign mode_chg = (mode_in != st_q.mode);
    assign step     = smp_valid && !mode_chg;

    mtd_magnitude #(.SAMPLE_W(SAMPLE_W)) u_mag (
        .sample (smp_data),
        .level  (trip_level),
        .hit    (hit)
    );

    mtd_persist #(.CNT_W(CNT_W)) u_persist (
        .mode    (mode_in),
        .clear   (mode_chg),
        .step    (step),
        .hit     (hit),
        .limit   (hold_limit),
        .cnt_q   (st_q.cnt),
        .cnt_d   (cnt_nxt),
        .reached (reached)
    );

    always_comb begin
        trip_set = 1'b0;
        if (step) begin
            unique case (mode_in)
                MODE_IMMED:                  trip_set = hit;
                MODE_CNT_CLR, MODE_CNT_LEAK: trip_set = reached;
                default:                     trip_set = 1'b0;
            endcase
        end
    end

    mtd_flag u_flag (
        .set    (trip_set),
        .ack    (irq_ack),
        .flag_q (st_q.irq),
        .flag_d (irq_nxt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_in;
        st_d.cnt  = cnt_nxt;
        st_d.irq  = irq_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq   = st_q.irq;
    assign count = st_q.cnt;
endmodule

// File: rtl/mtd_checker.sv
module mtd_checker #(
    parameter int SAMPLE_W = 16,
    parameter int CNT_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_valid,
    input logic [SAMPLE_W-1:0] smp_data,
    input logic [SAMPLE_W-1:0] trip_level,
    input logic [CNT_W-1:0]    hold_limit,
    input logic [1:0]          mode,
    input logic                irq_ack,
    input logic                irq,
    input logic [CNT_W-1:0]    count
);
    AST_OFF_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !irq) |=> !irq);                                  // R2

    AST_NONCOUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 || mode == 2'b01) |=> (count == '0));                // R2

    AST_TRIP_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(smp_valid));                                   // R3

    AST_SINGLE_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (count > $past(count)) |-> (count == CNT_W'($past(count) + 1'b1)));  // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !smp_valid) |=> !irq);                                  // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && $stable(mode) && (mode[1] == 1'b1)) |=> $stable(count)); // R7

    AST_MODE_SWITCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |=> (count == '0));                           // R8
endmodule

bind mag_trip_detector mtd_checker #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .smp_data   (smp_data),
    .trip_level (trip_level),
    .hold_limit (hold_limit),
    .mode       (mode),
    .irq_ack    (irq_ack),
    .irq        (irq),
    .count      (count)
);

// File: tb/sim_mag_trip_detector.sv
`timescale 1ns/1ps
module sim_mag_trip_detector;
    localparam int SW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic [SW-1:0] trip_level = 16'd100;
    logic [CW-1:0] hold_limit = 4'd3;
    logic [1:0]    mode = 2'b00;
    logic          irq_ack = 1'b0;
    logic          irq;
    logic [CW-1:0] count;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mag_trip_detector #(.SAMPLE_W(SW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .trip_level(trip_level), .hold_limit(hold_limit), .mode(mode),
        .irq_ack(irq_ack), .irq(irq), .count(count)
    );

    typedef struct packed {
        logic [1:0]  md;
        logic        vld;
        logic        ack;
        logic [15:0] smp;
        logic [15:0] th;
        logic [3:0]  lim;
        logic [3:0]  ecnt;
        logic        eirq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VEC [NV] = '{
        '{2'b00, 1'b1, 1'b0, 16'h01F4, 16'h0064, 4'd3, 4'd0, 1'b0, 8'd2},  // R2 off ignores big sample
        '{2'b01, 1'b1, 1'b0, 16'h0032, 16'h0064, 4'd3, 4'd0, 1'b0, 8'd8},  // R8 switch cycle
        '{2'b01, 1'b1, 1'b0, 16'h0032, 16'h0064, 4'd3, 4'd0, 1'b0, 8'd3},  // R3 below level
        '{2'b01, 1'b1, 1'b0, 16'hFF9C, 16'h0064, 4'd3, 4'd0, 1'b1, 8'd1},  // R1 |-100| >= 100
        '{2'b01, 1'b0, 1'b1, 16'h0000, 16'h0064, 4'd3, 4'd0, 1'b0, 8'd7},  // R7 ack
        '{2'b01, 1'b1, 1'b0, 16'h8000, 16'h7FFF, 4'd3, 4'd0, 1'b1, 8'd9},  // R9 saturated hit
        '{2'b01, 1'b0, 1'b1, 16'h0000, 16'h7FFF, 4'd3, 4'd0, 1'b0, 8'd7},  // R7 ack
        '{2'b01, 1'b1, 1'b0, 16'h8000, 16'h8000, 4'd3, 4'd0, 1'b0, 8'd9},  // R9 0x7FFF < 0x8000
        '{2'b10, 1'b1, 1'b0, 16'h00C8, 16'h0064, 4'd3, 4'd0, 1'b0, 8'd8},  // R8
        '{2'b10, 1'b1, 1'b0, 16'h00C8, 16'h0064, 4'd3, 4'd1, 1'b0, 8'd4},  // R4
        '{2'b10, 1'b1, 1'b0, 16'h0096, 16'h0064, 4'd3, 4'd2, 1'b0, 8'd4},  // R4
        '{2'b10, 1'b1, 1'b0, 16'h000A, 16'h0064, 4'd3, 4'd0, 1'b0, 8'd5},  // R5 miss clears
        '{2'b10, 1'b1, 1'b0, 16'h0064, 16'h0064, 4'd3, 4'd1, 1'b0, 8'd1},  // R1 equal qualifies
        '{2'b10, 1'b1, 1'b0, 16'hFED4, 16'h0064, 4'd3, 4'd2, 1'b0, 8'd1},  // R1 -300
        '{2'b10, 1'b0, 1'b0, 16'h0000, 16'h0064, 4'd3, 4'd2, 1'b0, 8'd7},  // R7 idle holds
        '{2'b10, 1'b1, 1'b0, 16'h0064, 16'h0064, 4'd3, 4'd3, 1'b1, 8'd4},  // R4 reach limit
        '{2'b10, 1'b1, 1'b0, 16'h0064, 16'h0064, 4'd3, 4'd3, 1'b1, 8'd4},  // R4 saturate
        '{2'b10, 1'b1, 1'b1, 16'h0064, 16'h0064, 4'd3, 4'd3, 1'b1, 8'd7},  // R7 set beats ack
        '{2'b10, 1'b1, 1'b1, 16'h0005, 16'h0064, 4'd3, 4'd0, 1'b0, 8'd5},  // R5
        '{2'b11, 1'b1, 1'b0, 16'h00C8, 16'h0064, 4'd3, 4'd0, 1'b0, 8'd8},  // R8
        '{2'b11, 1'b1, 1'b0, 16'h00C8, 16'h0064, 4'd3, 4'd1, 1'b0, 8'd4},  // R4
        '{2'b11, 1'b1, 1'b0, 16'h00C8, 16'h0064, 4'd3, 4'd2, 1'b0, 8'd4},  // R4
        '{2'b11, 1'b1, 1'b0, 16'h0032, 16'h0064, 4'd3, 4'd1, 1'b0, 8'd6},  // R6 leak
        '{2'b11, 1'b1, 1'b0, 16'h00C8, 16'h0064, 4'd3, 4'd2, 1'b0, 8'd6},  // R6
        '{2'b11, 1'b1, 1'b0, 16'h00C8, 16'h0064, 4'd3, 4'd3, 1'b1, 8'd6},  // R6 trips despite dip
        '{2'b11, 1'b0, 1'b1, 16'h0000, 16'h0064, 4'd3, 4'd3, 1'b0, 8'd7},  // R7
        '{2'b11, 1'b1, 1'b0, 16'h0000, 16'h0064, 4'd3, 4'd2, 1'b0, 8'd6},  // R6
        '{2'b11, 1'b1, 1'b0, 16'h0000, 16'h0064, 4'd3, 4'd1, 1'b0, 8'd6},  // R6
        '{2'b11, 1'b1, 1'b0, 16'h0000, 16'h0064, 4'd3, 4'd0, 1'b0, 8'd6},  // R6
        '{2'b11, 1'b1, 1'b0, 16'h0000, 16'h0064, 4'd3, 4'd0, 1'b0, 8'd6},  // R6 floor at 0
        '{2'b11, 1'b1, 1'b0, 16'h00C8, 16'h0064, 4'd0, 4'd0, 1'b1, 8'd10}, // R10 limit 0
        '{2'b00, 1'b0, 1'b1, 16'h0000, 16'h0064, 4'd0, 4'd0, 1'b0, 8'd8},  // R8
        '{2'b00, 1'b1, 1'b0, 16'h7530, 16'h0064, 4'd3, 4'd0, 1'b0, 8'd2}   // R2
    };

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic [1:0] md, input logic vld, input logic ack,
                         input logic [15:0] smp);
        @(negedge clk);
        mode = md; smp_valid = vld; irq_ack = ack; smp_data = smp;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R11 reset state, with inputs that would otherwise trip
        mode = 2'b01; smp_valid = 1'b1; smp_data = 16'h0FFF;
        repeat (3) @(posedge clk);
        #1;
        check("R11 count in reset", int'(count), 0);
        check("R11 irq in reset", int'(irq), 0);
        @(negedge clk);
        mode = 2'b00; smp_valid = 1'b0; rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mode = VEC[i].md; smp_valid = VEC[i].vld; irq_ack = VEC[i].ack;
            smp_data = VEC[i].smp; trip_level = VEC[i].th; hold_limit = VEC[i].lim;
            @(posedge clk);
            #1;
            check($sformatf("R%0d vec %0d count", VEC[i].req, i), int'(count), int'(VEC[i].ecnt));
            check($sformatf("R%0d vec %0d irq", VEC[i].req, i), int'(irq), int'(VEC[i].eirq));
        end

        // R4 saturation at the widest limit
        trip_level = 16'd100; hold_limit = 4'd15;
        cycle(2'b10, 1'b1, 1'b0, 16'd500);
        for (int k = 0; k < 14; k++) cycle(2'b10, 1'b1, 1'b0, 16'd500);
        check("R4 count 14 below limit", int'(count), 14);
        check("R4 no trip before limit", int'(irq), 0);
        cycle(2'b10, 1'b1, 1'b0, 16'd500);
        cycle(2'b10, 1'b1, 1'b0, 16'd500);
        check("R4 saturates at 15", int'(count), 15);
        check("R4 trip at 15", int'(irq), 1);
        cycle(2'b10, 1'b0, 1'b1, 16'd0);
        check("R7 ack clears", int'(irq), 0);
        check("R7 count held", int'(count), 15);
        // R8 switching modes with a full count discards the sample
        cycle(2'b11, 1'b1, 1'b0, 16'd500);
        check("R8 switch clears count", int'(count), 0);
        check("R8 switch sample no trip", int'(irq), 0);

        // R11 reset in mid-run
        cycle(2'b11, 1'b1, 1'b0, 16'd500);
        hold_limit = 4'd1;
        cycle(2'b11, 1'b1, 1'b0, 16'd500);
        check("R4 pre-reset trip", int'(irq), 1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R11 async count", int'(count), 0);
        check("R11 async irq", int'(irq), 0);
        @(negedge clk);
        rst_n = 1'b1;
        finish_run();
    end
endmodule